// File: doc/BRIEF.md
# Poll Response Timeout and Retry Supervisor

This block watches the request and response traffic of a master that polls one serial device. Each request arms a response window that is counted in base ticks. If the window runs out with no valid response, the block emits a timeout event pulse. It also asks for a retry, unless this failure reaches the consecutive-failure limit. At the limit it marks the device absent and raises an alarm. Both flags stay set until a response arrives for a later request, or until the clear input is driven.

The same tick also drives a line-silence detector. The tick is one half of a character time, so the detector counts half-characters from the last receive activity. At the configured count, which defaults to seven (three and a half characters), it signals the end of a frame once. The tick period and both counts are parameters, so any baud rate is covered by supplying the right tick.

Top module: `poll_supervisor`

## Requirements
- R1: After reset, retry_o, tmo_o, frame_end_o, absent_o and alarm_o are all 0.
- R2: When RSP_TICKS ticks have been seen since the last req_sent_i with no response, tmo_o is 1 for exactly one cycle, in the cycle after the clock edge that samples the final tick. No tmo_o appears before that tick.
- R3: retry_o is 1 in the same cycle as tmo_o when that failure leaves the consecutive-failure count below MAX_FAILS. On the failure that reaches MAX_FAILS, no retry is requested.
- R4: On the MAX_FAILS-th consecutive failure, absent_o and alarm_o go to 1 together and stay at 1 across later cycles and timeouts.
- R5: An rsp_ok_i while a request is outstanding is a success. It closes the window, sets the failure count to zero, and clears absent_o and alarm_o.
- R6: An rsp_ok_i in the same cycle as the expiring tick counts as a success. No tmo_o or retry_o is produced, and the failure count is cleared.
- R7: An rsp_ok_i while no request is outstanding is ignored. It does not clear absent_o or alarm_o.
- R8: A req_sent_i restarts the response window from zero ticks, even when a request is already outstanding.
- R9: clr_i sets the failure count to zero and clears absent_o and alarm_o.
- R10: frame_end_o pulses for one cycle after GAP_HALVES ticks have passed since the last rx_act_i. It pulses once per burst, and any rx_act_i, including one in the same cycle as a tick, restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base tick strobe, one half character time |
| req_sent_i | input | 1 | Request has been transmitted |
| rsp_ok_i | input | 1 | Valid response received |
| rx_act_i | input | 1 | Receive line activity strobe |
| clr_i | input | 1 | Clears the absent flag, the alarm and the failure count |
| retry_o | output | 1 | One-cycle retry request |
| tmo_o | output | 1 | One-cycle timeout event |
| frame_end_o | output | 1 | One-cycle end-of-frame indication |
| absent_o | output | 1 | Device declared absent |
| alarm_o | output | 1 | Alarm raised with absence |

## Verification
The response path is driven through four patterns. A silent window must expire on exactly the final tick. A response inside the window must prevent any event. A response on the expiring tick separates the success-first priority from an off-by-one window. A request sent again mid-window shows whether the timer restarts or keeps its count. Failure sequences with a success in the middle tell a consecutive count apart from a cumulative one. A response with no request outstanding shows whether such responses are correctly ignored. On the silence detector, a burst interrupted after five ticks and a steady run of ticks check the restart on activity and the single pulse per burst.

// File: rtl/poll_supervisor.sv
module poll_supervisor #(
  parameter int RSP_TICKS  = 288,
  parameter int GAP_HALVES = 7,
  parameter int MAX_FAILS  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic req_sent_i,
  input  logic rsp_ok_i,
  input  logic rx_act_i,
  input  logic clr_i,
  output logic retry_o,
  output logic tmo_o,
  output logic frame_end_o,
  output logic absent_o,
  output logic alarm_o
);
  localparam int RW = $clog2(RSP_TICKS + 1);
  localparam int GW = $clog2(GAP_HALVES + 1);
  localparam int FW = $clog2(MAX_FAILS + 1);

  logic          wait_q;
  logic [RW-1:0] rsp_cnt;
  logic          gap_arm;
  logic [GW-1:0] gap_cnt;
  logic [FW-1:0] fail_cnt;

  wire expire  = wait_q & tick_i & (rsp_cnt == RW'(RSP_TICKS - 1));
  wire success = wait_q & rsp_ok_i;
  wire fail    = expire & ~rsp_ok_i;
  wire at_last = fail_cnt >= FW'(MAX_FAILS - 1);
  wire absent_d = ~(success | clr_i) & (absent_o | (fail & at_last));
  wire gap_done = gap_arm & tick_i & ~rx_act_i & (gap_cnt == GW'(GAP_HALVES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= 1'b0;
      rsp_cnt <= '0;
    end else if (req_sent_i) begin
      wait_q  <= 1'b1;
      rsp_cnt <= '0;
    end else if (success || expire) begin
      wait_q  <= 1'b0;
      rsp_cnt <= '0;
    end else if (wait_q && tick_i) begin
      rsp_cnt <= rsp_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fail_cnt <= '0;
    else if (success || clr_i)
      fail_cnt <= '0;
    else if (fail && fail_cnt < FW'(MAX_FAILS))
      fail_cnt <= fail_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_o    <= 1'b0;
      retry_o  <= 1'b0;
      absent_o <= 1'b0;
      alarm_o  <= 1'b0;
    end else begin
      tmo_o    <= fail;
      retry_o  <= fail & ~absent_d;
      absent_o <= absent_d;
      alarm_o  <= absent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_arm     <= 1'b0;
      gap_cnt     <= '0;
      frame_end_o <= 1'b0;
    end else begin
      frame_end_o <= gap_done;
      if (rx_act_i) begin
        gap_arm <= 1'b1;
        gap_cnt <= '0;
      end else if (gap_done) begin
        gap_arm <= 1'b0;
        gap_cnt <= '0;
      end else if (gap_arm && tick_i) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/poll_supervisor_chk.sv
module poll_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic rsp_ok_i,
  input logic clr_i,
  input logic wait_q,
  input logic retry_o,
  input logic tmo_o,
  input logic frame_end_o,
  input logic absent_o,
  input logic alarm_o
);
  a_r2_tmo_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |=> !tmo_o);
  a_r3_retry_with_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> tmo_o);
  a_r4_alarm_tracks_absent: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o == absent_o);
  a_r4_absent_needs_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(absent_o) |-> tmo_o);
  a_r5_success_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ok_i && wait_q) |=> (!absent_o && !tmo_o && !retry_o));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !absent_o);
  a_r10_fe_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> !frame_end_o);
endmodule

bind poll_supervisor poll_supervisor_chk u_chk (.*);

// File: tb/poll_supervisor_tb.sv
`timescale 1ns/1ps
module poll_supervisor_tb;
  localparam int RT = 8;
  localparam int GH = 7;
  localparam int MF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 0, req_sent_i = 0, rsp_ok_i = 0, rx_act_i = 0, clr_i = 0;
  logic retry_o, tmo_o, frame_end_o, absent_o, alarm_o;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  poll_supervisor #(.RSP_TICKS(RT), .GAP_HALVES(GH), .MAX_FAILS(MF)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .req_sent_i(req_sent_i),
    .rsp_ok_i(rsp_ok_i), .rx_act_i(rx_act_i), .clr_i(clr_i),
    .retry_o(retry_o), .tmo_o(tmo_o), .frame_end_o(frame_end_o),
    .absent_o(absent_o), .alarm_o(alarm_o));

  task automatic check(string r, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", r, act, exp);
    end
  endtask

  task automatic cyc(logic t, logic rq, logic rs, logic rx, logic cl);
    tick_i = t; req_sent_i = rq; rsp_ok_i = rs; rx_act_i = rx; clr_i = cl;
    @(negedge clk);
    tick_i = 0; req_sent_i = 0; rsp_ok_i = 0; rx_act_i = 0; clr_i = 0;
  endtask

  task automatic ticks_quiet(int n, string r);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 0, 0);
      if (tmo_o || frame_end_o) seen++;
    end
    check(r, seen != 0, 1'b0);
  endtask

  task automatic fail_once(string r, logic exp_retry, logic exp_absent);
    cyc(0, 1, 0, 0, 0);
    ticks_quiet(RT - 1, {r, " early"});
    cyc(1, 0, 0, 0, 0);
    check({r, " tmo"}, tmo_o, 1'b1);
    check({r, " retry"}, retry_o, exp_retry);
    check({r, " absent"}, absent_o, exp_absent);
    check({r, " alarm"}, alarm_o, exp_absent);
    cyc(0, 0, 0, 0, 0);
    check({r, " tmo one cycle"}, tmo_o, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 retry", retry_o, 1'b0);
    check("R1 tmo", tmo_o, 1'b0);
    check("R1 frame_end", frame_end_o, 1'b0);
    check("R1 absent", absent_o, 1'b0);
    check("R1 alarm", alarm_o, 1'b0);
  endtask

  task automatic t_three_fails();
    fail_once("R2 R3 fail1", 1'b1, 1'b0);
    fail_once("R3 fail2", 1'b1, 1'b0);
    fail_once("R4 fail3", 1'b0, 1'b1);
    repeat (5) cyc(0, 0, 0, 0, 0);
    check("R4 absent held", absent_o, 1'b1);
    fail_once("R4 fail4 stays absent", 1'b0, 1'b1);
  endtask

  task automatic t_unsolicited();
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    check("R7 absent kept", absent_o, 1'b1);
    check("R7 alarm kept", alarm_o, 1'b1);
  endtask

  task automatic t_success_clears();
    cyc(0, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    check("R5 absent cleared", absent_o, 1'b0);
    check("R5 alarm cleared", alarm_o, 1'b0);
    ticks_quiet(RT + 2, "R5 no tmo after response");
    fail_once("R5 count reset a", 1'b1, 1'b0);
    fail_once("R5 count reset b", 1'b1, 1'b0);
    cyc(0, 1, 0, 0, 0);
    ticks_quiet(RT - 1, "R6 early");
    cyc(1, 0, 1, 0, 0);
    check("R6 no tmo", tmo_o, 1'b0);
    check("R6 no retry", retry_o, 1'b0);
    fail_once("R6 count cleared", 1'b1, 1'b0);
    fail_once("R5 second", 1'b1, 1'b0);
    fail_once("R5 third", 1'b0, 1'b1);
  endtask

  task automatic t_clear();
    cyc(0, 0, 0, 0, 1);
    check("R9 absent", absent_o, 1'b0);
    check("R9 alarm", alarm_o, 1'b0);
    fail_once("R9 count cleared", 1'b1, 1'b0);
  endtask

  task automatic t_rearm();
    cyc(0, 0, 0, 0, 1);
    cyc(0, 1, 0, 0, 0);
    ticks_quiet(RT - 2, "R8 first part");
    cyc(0, 1, 0, 0, 0);
    ticks_quiet(RT - 1, "R8 restarted");
    cyc(1, 0, 0, 0, 0);
    check("R8 tmo after full window", tmo_o, 1'b1);
  endtask

  task automatic t_gap();
    int seen = 0;
    cyc(0, 0, 0, 1, 0);
    ticks_quiet(GH - 1, "R10 before gap");
    cyc(1, 0, 0, 0, 0);
    check("R10 frame_end", frame_end_o, 1'b1);
    cyc(0, 0, 0, 0, 0);
    check("R10 one cycle", frame_end_o, 1'b0);
    for (int i = 0; i < 2 * GH; i++) begin
      cyc(1, 0, 0, 0, 0);
      if (frame_end_o) seen++;
    end
    check("R10 once per burst", seen != 0, 1'b0);
    cyc(0, 0, 0, 1, 0);
    ticks_quiet(GH - 2, "R10 restart a");
    cyc(1, 0, 0, 1, 0);
    ticks_quiet(GH - 1, "R10 restart b");
    cyc(1, 0, 0, 0, 0);
    check("R10 frame_end after restart", frame_end_o, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_three_fails();
    t_unsolicited();
    t_success_clears();
    t_clear();
    t_rearm();
    t_gap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule